// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transmitter and receiver. It is run from one 8-bit control register. Software uses that register to pick a frame of 8 or 9 data bits, to turn hardware parity on or off, to choose even or odd parity, to enable an interrupt on a parity error, and to put the block into a low-power off state. A small register port gives access to the control register, a status register and a data register. A write to the data register queues one character for sending. A read of the data register returns the last character received.

When parity is on, the parity bit is not added to the frame. It takes the place of the top data bit of the word. A frame is one start bit, the data bits least significant first, and one stop bit. Each bit lasts 16 pulses of an external oversampling tick. The receiver samples in the middle of each bit.

Settings are captured at the start of each frame, so writing the control register in the middle of a frame has no effect until the next frame. A parity error is cleared by a two-step sequence: a status read, followed by an access to the data register. This keeps software from missing an error that arrives while it is busy.

Top module: `uart_xcvr`

## Requirements
- R1: The control register is at address 0. Its bits are, from 7 down to 0: r8, t8, off, len9, wake, par_en, par_odd, pe_ie. All bits can be read and written. After reset the register reads 0x00.
- R2: The tx_o line is high when idle and for the stop bit, and low for the start bit. Data goes out least significant bit first, and each bit lasts 16 ticks. A frame has 8 data bits when len9=0 and 9 data bits when len9=1. The ninth bit is taken from t8.
- R3: When par_en=1, the top data position (bit 7 with len9=0, bit 8 with len9=1) carries parity computed over the bits below it. par_odd=0 gives even parity and par_odd=1 gives odd parity.
- R4: When a frame is received, its low 8 bits are stored in the data register (address 2, read). Its ninth bit goes to r8 when len9=1. Status bit 1 (rx_full) is set, and a data read clears it.
- R5: When a frame is received with par_en=1 and its top bit does not match the parity of the lower bits, status bit 0 (pe) is set. A frame with matching parity leaves pe clear.
- R6: irq_o is high exactly while pe=1 and pe_ie=1.
- R7: pe clears only on a data-register access that comes after a status read (address 1) made since the error. A data access without that read leaves pe set.
- R8: The len9, par_en, par_odd and t8 settings are captured when a frame starts. Changing them during a frame does not affect that frame.
- R9: Setting off lets the current frame finish. While off=1 no new frame starts, tx_o stays high, and a queued character waits, shown by status bit 2 (tx_busy). Clearing off sends the queued character.
- R10: The receiver drops a start bit that is no longer low at its midpoint, and no character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Parity-error interrupt |

## Verification
The bench holds tick_i high, so one bit takes 16 clocks. A character written to the data register starts on tx_o two clocks after the write edge. The bench first finds the falling start edge, then samples every bit at half a clock plus 8 clocks into the bit and every 16 clocks after that. Received characters reach the registers about three clocks after the middle of the stop bit, because of the two-stage input synchronizer. The bench therefore reads status and data no earlier than 20 clocks after the frame ends. Register reads return combinationally and are sampled 1 ns after the falling edge while the strobe is held.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  localparam int REG_AW = 2;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 9;

  typedef enum logic [REG_AW-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic r8;
    logic t8;
    logic off;
    logic len9;
    logic wake;
    logic par_en;
    logic par_odd;
    logic pe_ie;
  } ctrl_t;

  typedef struct packed {
    logic len9;
    logic par_en;
    logic par_odd;
  } frame_cfg_t;

  // parity over the bits below the parity slot
  function automatic logic par_bit(input logic [BYTE_W-1:0] lo, input logic len9,
                                   input logic odd);
    logic [BYTE_W-1:0] m;
    m = len9 ? lo : {1'b0, lo[BYTE_W-2:0]};
    return (^m) ^ odd;
  endfunction
endpackage

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
  import uart_xcvr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              off_i,
  input  frame_cfg_t        cfg_i,
  input  logic              t8_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              active_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int CW = $clog2(OVS);
  localparam int FW = WORD_W + 2;
  localparam int NW = $clog2(FW + 1);

  logic [FW-1:0]     sh_q;
  logic [NW-1:0]     left_q;
  logic [CW-1:0]     tcnt_q;
  logic              active_q, pend_q;
  logic [BYTE_W-1:0] hold_q;
  logic [WORD_W-1:0] word;
  logic              start;

  assign start = !active_q && pend_q && !off_i && tick_i;

  always_comb begin
    word = {t8_i & cfg_i.len9, hold_q};
    if (cfg_i.par_en) begin
      if (cfg_i.len9) word[8] = par_bit(hold_q, 1'b1, cfg_i.par_odd);
      else            word[7] = par_bit(hold_q, 1'b0, cfg_i.par_odd);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      hold_q <= data_i;
    end else if (start) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sh_q     <= '1;
      left_q   <= '0;
      tcnt_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      tcnt_q   <= '0;
      sh_q     <= cfg_i.len9 ? {1'b1, word, 1'b0} : {2'b11, word[7:0], 1'b0};
      left_q   <= cfg_i.len9 ? NW'(FW) : NW'(FW - 1);
    end else if (active_q && tick_i) begin
      if (tcnt_q == CW'(OVS - 1)) begin
        tcnt_q <= '0;
        if (left_q == NW'(1)) active_q <= 1'b0;
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - NW'(1);
      end else begin
        tcnt_q <= tcnt_q + CW'(1);
      end
    end
  end

  assign tx_o     = active_q ? sh_q[0] : 1'b1;
  assign active_o = active_q;
  assign busy_o   = active_q | pend_q;

  a_r9_no_start_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(!off_i));
  a_r2_frame_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> left_q == ($past(cfg_i.len9) ? NW'(FW) : NW'(FW - 1)));
endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
  import uart_xcvr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              off_i,
  input  frame_cfg_t        cfg_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              len9_o,
  output logic              perr_o,
  output logic              busy_o
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(WORD_W + 1);
  localparam int HALF = OVS / 2 - 1;

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_e;

  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic              rxs;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [WORD_W-1:0] word_q;
  frame_cfg_t        cfg_q;
  logic              done_q, perr_q;
  logic              top;

  assign rxs = sync_q[1];
  assign top = cfg_q.len9 ? word_q[8] : word_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= R_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      word_q  <= '0;
      cfg_q   <= '0;
      done_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          R_IDLE: if (!rxs && !off_i) begin
            state_q <= R_START;
            cnt_q   <= '0;
            cfg_q   <= cfg_i;
            word_q  <= '0;
          end
          R_START: begin
            if (cnt_q == CW'(HALF)) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              state_q <= rxs ? R_IDLE : R_DATA;
            end else cnt_q <= cnt_q + CW'(1);
          end
          R_DATA: begin
            if (cnt_q == CW'(OVS - 1)) begin
              cnt_q         <= '0;
              word_q[bit_q] <= rxs;
              if (bit_q == (cfg_q.len9 ? BW'(8) : BW'(7))) state_q <= R_STOP;
              else bit_q <= bit_q + BW'(1);
            end else cnt_q <= cnt_q + CW'(1);
          end
          R_STOP: begin
            if (cnt_q == CW'(OVS - 1)) begin
              cnt_q   <= '0;
              state_q <= R_IDLE;
              done_q  <= 1'b1;
              perr_q  <= cfg_q.par_en &&
                         (top != par_bit(word_q[7:0], cfg_q.len9, cfg_q.par_odd));
            end else cnt_q <= cnt_q + CW'(1);
          end
          default: state_q <= R_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign word_o = word_q;
  assign len9_o = cfg_q.len9;
  assign perr_o = perr_q;
  assign busy_o = state_q != R_IDLE;

  a_r10_false_start_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == R_START && tick_i && cnt_q == CW'(HALF) && rxs) |=> state_q == R_IDLE);
  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != R_IDLE && $past(state_q != R_IDLE)) |-> $stable(cfg_q));
  a_r2_bit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == R_DATA |-> bit_q <= (cfg_q.len9 ? BW'(8) : BW'(7)));
endmodule

// File: rtl/uart_xcvr_regs.sv
module uart_xcvr_regs
  import uart_xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_busy_i,
  input  logic              rx_done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_len9_i,
  input  logic              rx_perr_i,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] rx_data_q;
  logic              pe_q, arm_q, full_q;
  logic              ctrl_wr, stat_rd, data_acc, data_rd, pe_set;

  assign ctrl_wr  = req_i && we_i && addr_i == ADDR_CTRL;
  assign stat_rd  = req_i && !we_i && addr_i == ADDR_STAT;
  assign data_acc = req_i && addr_i == ADDR_DATA;
  assign data_rd  = data_acc && !we_i;
  assign pe_set   = rx_done_i && rx_perr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i);
      if (rx_done_i && rx_len9_i) ctrl_q.r8 <= rx_word_i[8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0;
      full_q    <= 1'b0;
      pe_q      <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      if (rx_done_i) begin
        rx_data_q <= rx_word_i[7:0];
        full_q    <= 1'b1;
      end else if (data_rd) full_q <= 1'b0;

      if (pe_set) pe_q <= 1'b1;
      else if (arm_q && data_acc) pe_q <= 1'b0;

      if (pe_set || data_acc) arm_q <= 1'b0;
      else if (stat_rd) arm_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: rdata_o = {5'b0, tx_busy_i, full_q, pe_q};
      ADDR_DATA: rdata_o = rx_data_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign tx_load_o = data_acc && we_i;
  assign tx_data_o = wdata_i;
  assign irq_o     = pe_q && ctrl_q.pe_ie;

  a_r7_clear_needs_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pe_q) |-> $past(arm_q && data_acc));
  a_r5_set_on_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pe_q) |-> $past(rx_done_i && rx_perr_i));
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        rx_i,
  output logic        tx_o,
  output logic        irq_o
);
  ctrl_t             ctrl;
  frame_cfg_t        cfg;
  logic              tx_load, tx_active, tx_busy;
  logic [BYTE_W-1:0] tx_data;
  logic              rx_done, rx_len9, rx_perr, rx_busy;
  logic [WORD_W-1:0] rx_word;
  logic              tick_g;

  assign cfg    = '{len9: ctrl.len9, par_en: ctrl.par_en, par_odd: ctrl.par_odd};
  // prescale stops once off and both directions idle
  assign tick_g = tick_i && !(ctrl.off && !tx_active && !rx_busy);

  uart_xcvr_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ctrl_o(ctrl), .tx_load_o(tx_load), .tx_data_o(tx_data), .tx_busy_i(tx_busy),
    .rx_done_i(rx_done), .rx_word_i(rx_word), .rx_len9_i(rx_len9),
    .rx_perr_i(rx_perr), .irq_o
  );

  uart_xcvr_tx #(.OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick_g), .off_i(ctrl.off), .cfg_i(cfg), .t8_i(ctrl.t8),
    .load_i(tx_load), .data_i(tx_data), .active_o(tx_active), .busy_o(tx_busy), .tx_o
  );

  uart_xcvr_rx #(.OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick_g), .off_i(ctrl.off), .cfg_i(cfg), .rx_i,
    .done_o(rx_done), .word_o(rx_word), .len9_o(rx_len9), .perr_o(rx_perr),
    .busy_o(rx_busy)
  );
endmodule

// File: tb/sim_uart_xcvr.sv
`timescale 1ns/1ps
module sim_uart_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic tx, irq, rx_drv = 1'b1, lb = 1'b0, rx_line;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign rx_line = lb ? tx : rx_drv;

  uart_xcvr u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx_line),
    .tx_o(tx), .irq_o(irq)
  );

  // {ctrl, data, expected 9-bit word on the line}
  localparam logic [24:0] VEC [0:6] = '{
    {8'h00, 8'hA5, 9'h0A5},
    {8'h04, 8'h07, 9'h087},
    {8'h06, 8'h05, 9'h085},
    {8'h50, 8'h3C, 9'h13C},
    {8'h14, 8'h01, 9'h101},
    {8'h16, 8'h0F, 9'h10F},
    {8'h10, 8'h80, 9'h080}
  };

  task automatic check(input string req_s, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_s, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic capture(input int nb, output logic [8:0] w, output logic ok);
    logic st, sp;
    int n;
    w = '0; ok = 1'b0; n = 0;
    while (tx !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) return;
    repeat (8) @(negedge clk);
    st = tx;
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      w[i] = tx;
    end
    repeat (16) @(negedge clk);
    sp = tx;
    ok = (st == 1'b0) && (sp == 1'b1);
  endtask

  task automatic send_rx(input logic [8:0] w, input int nb);
    @(negedge clk); rx_drv = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_drv = w[i];
      repeat (16) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [8:0] w;
    logic ok;
    int lows;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and read/write
    bus_rd(2'd0, d); check("R1", "ctrl reset", d, 8'h00);
    bus_rd(2'd1, d); check("R1", "status reset", d, 8'h00);
    check("R2", "idle line", tx, 1'b1);
    check("R6", "irq reset", irq, 1'b0);
    bus_wr(2'd0, 8'h4F);
    bus_rd(2'd0, d); check("R1", "ctrl readback", d, 8'h4F);
    bus_wr(2'd0, 8'h00);

    // table walk, loopback through the receiver
    lb = 1'b1;
    for (int i = 0; i < 7; i++) begin
      logic [7:0] c;
      int nb;
      c  = VEC[i][24:17];
      nb = c[4] ? 9 : 8;
      bus_wr(2'd0, c);
      bus_wr(2'd2, VEC[i][16:9]);
      capture(nb, w, ok);
      check("R2", "start/stop framing", ok, 1'b1);
      if (nb == 9) check(c[2] ? "R3" : "R2", "tx word len9", w, VEC[i][8:0]);
      else check(c[2] ? "R3" : "R2", "tx word len8", w[7:0], VEC[i][7:0]);
      repeat (40) @(negedge clk);
      bus_rd(2'd1, d); check("R5", "status after good frame", d, 8'h02);
      bus_rd(2'd2, d); check("R4", "rx data", d, VEC[i][7:0]);
      if (nb == 9) begin
        bus_rd(2'd0, d); check("R4", "r8 from ninth bit", d[7], VEC[i][8]);
      end
    end

    // R8 parity enable written mid-frame
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd2, 8'h07);
    fork
      capture(8, w, ok);
      begin repeat (60) @(negedge clk); bus_wr(2'd0, 8'h04); end
    join
    check("R8", "par_en mid-frame ignored", w[7:0], 8'h07);
    repeat (40) @(negedge clk);
    bus_rd(2'd2, d);
    bus_wr(2'd2, 8'h07);
    capture(8, w, ok);
    check("R8", "par_en on next frame", w[7:0], 8'h87);
    repeat (40) @(negedge clk);
    bus_rd(2'd2, d);

    // R8 length written mid-frame: stop must follow bit 7
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd2, 8'hA5);
    fork
      capture(8, w, ok);
      begin repeat (60) @(negedge clk); bus_wr(2'd0, 8'h10); end
    join
    check("R8", "len9 mid-frame ignored", {ok, w[7:0]}, 9'h1A5);
    repeat (40) @(negedge clk);
    bus_rd(2'd2, d); check("R8", "rx len8 kept", d, 8'hA5);

    // R9 off during a frame
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd2, 8'h5A);
    fork
      capture(8, w, ok);
      begin repeat (40) @(negedge clk); bus_wr(2'd0, 8'h20); end
    join
    check("R9", "frame finishes after off", {ok, w[7:0]}, 9'h15A);
    repeat (40) @(negedge clk);
    bus_rd(2'd2, d);
    bus_wr(2'd2, 8'h33);
    bus_rd(2'd1, d); check("R9", "queued shows tx_busy", d, 8'h04);
    lows = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (tx == 1'b0) lows++; end
    check("R9", "line held while off", lows[15:0], 16'd0);
    bus_wr(2'd0, 8'h00);
    capture(8, w, ok);
    check("R9", "queued sent after on", {ok, w[7:0]}, 9'h133);
    repeat (40) @(negedge clk);
    bus_rd(2'd2, d);

    // R10 false start
    lb = 1'b0;
    @(negedge clk); rx_drv = 1'b0;
    repeat (5) @(negedge clk); rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    bus_rd(2'd1, d); check("R10", "glitch not stored", d, 8'h00);
    send_rx(9'h0C3, 8);
    repeat (20) @(negedge clk);
    bus_rd(2'd1, d); check("R10", "next frame received", d, 8'h02);
    bus_rd(2'd2, d); check("R4", "rx driven data", d, 8'hC3);

    // R5/R6/R7 parity error and clear sequence
    bus_wr(2'd0, 8'h05);
    send_rx(9'h007, 8);
    repeat (20) @(negedge clk);
    check("R6", "irq on pe", irq, 1'b1);
    bus_rd(2'd2, d); check("R4", "bad-parity data", d, 8'h07);
    bus_rd(2'd1, d); check("R7", "pe kept without status read", d, 8'h01);
    bus_wr(2'd0, 8'h04);
    @(negedge clk);
    check("R6", "irq masked", irq, 1'b0);
    bus_rd(2'd2, d);
    bus_rd(2'd1, d); check("R7", "pe cleared by sequence", d, 8'h00);
    send_rx(9'h087, 8);
    repeat (20) @(negedge clk);
    bus_rd(2'd1, d); check("R5", "good parity no pe", d, 8'h02);
    check("R6", "irq low", irq, 1'b0);
    bus_rd(2'd2, d);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule